// File: doc/BRIEF.md
# Duplicate-Tag Snoop Invalidation Unit

This unit keeps a direct-mapped data cache coherent with writes made by other agents on the system bus. It holds a shadow copy of the cache tag store. Each shadow entry holds the block's upper address bits, a valid flag and an even-parity bit over both. The shadow entry is written on the same cycle the cache allocates a block. Every write seen on the bus is looked up in the shadow copy, so the main tag store is disturbed only by writes that really touch a cached block.

A write that hits produces an invalidate request carrying the block index. The request waits in a short first-in first-out queue until the main tag store can accept it. While the queue is full, the snoop port is held off. A shadow entry whose parity does not check is treated as a hit, so a corrupted entry can only cause an extra invalidate and never a missed one.

An address splits into three fields. The low `OFF_W` bits are the byte offset within a block. The next `IDX_W` bits are the index. The top `TAG_W` bits are the tag. Blocks are 32 bytes.

Top module: `snoop_inv_unit`

## Requirements
- R1: After reset, `inv_valid` is 0 and `snoop_ready` is 1. Every shadow entry is invalid, so no bus write produces an invalidate until a block has been allocated.
- R2: After an allocation of address A, a later accepted bus write whose tag and index equal those of A produces exactly one invalidate with `inv_index` equal to A's index.
- R3: A bus write produces no invalidate if its tag differs from the stored tag at its index, or if it targets an index that holds no valid entry. The offset bits take no part in the comparison.
- R4: A hit clears the valid flag of the shadow entry. A second write to the same block, with no allocation in between, produces no further invalidate.
- R5: Invalidates leave in the order their writes were accepted. While `inv_valid` is 1 and `inv_ready` is 0, `inv_valid` and `inv_index` stay unchanged. One request is removed on each cycle in which both are 1.
- R6: The queue holds four requests. While four are pending, `snoop_ready` is 0, and a write presented on that cycle is ignored: it neither enqueues a request nor changes the shadow store.
- R7: When an allocation and a bus write to the same index occur in one cycle, the write is compared against the entry as it was before that cycle. The newly allocated entry is stored valid.
- R8: A new allocation at an index replaces the stored tag. Writes to the old tag then miss, and writes to the new tag hit.
- R9: `inv_valid` rises on the cycle after the clock edge that accepted the hitting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Cache allocates the block at `alloc_addr` this cycle |
| alloc_addr | input | ADDR_W | Physical address of the allocated block |
| snoop_valid | input | 1 | A bus write is presented |
| snoop_addr | input | ADDR_W | Physical address of the bus write |
| snoop_ready | output | 1 | Bus write is accepted when high together with `snoop_valid` |
| inv_valid | output | 1 | An invalidate request is pending for the main tag store |
| inv_index | output | IDX_W | Index whose main-tag valid bit is to be cleared |
| inv_ready | input | 1 | Main tag store takes the pending request this cycle |

## Verification
Some properties are checked on every cycle by the assertions. These are the agreement between `snoop_ready` and a queue fill that is counted independently, the presence of a request exactly when that count is non-zero, and the holding of a stalled request. They also check that a hit is never followed by a second hit on the same block while no allocation intervenes. Other behaviour can only be shown by the bench's scenarios. That covers tag and index filtering, offset independence, in-order delivery, the write ignored while the queue is full, replacement of a tag, and the same-cycle allocation and snoop.

// File: rtl/snoop_inv_pkg.sv
package snoop_inv_pkg;
    // Block geometry defaults: 32-byte blocks, 9-bit tag field.
    localparam int unsigned SNP_OFF_W  = 5;
    localparam int unsigned SNP_TAG_W  = 9;
    // Default index width kept small enough for a flop-based shadow store.
    localparam int unsigned SNP_IDX_W  = 10;
    localparam int unsigned SNP_QDEPTH = 4;
endpackage

// File: rtl/dtag_store.sv
module dtag_store #(
    parameter int unsigned IDX_W = 10,
    parameter int unsigned TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    output logic             rd_par
);
    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned ENT_W   = TAG_W + 2;   // {par, vld, tag}

    logic [ENT_W-1:0] mem_d [ENTRIES];
    logic [ENT_W-1:0] mem_q [ENTRIES];
    logic [TAG_W-1:0] clr_tag;

    assign clr_tag = mem_q[clr_idx][TAG_W-1:0];

    always_comb begin
        mem_d = mem_q;
        if (clr_en) begin
            mem_d[clr_idx] = {^{1'b0, clr_tag}, 1'b0, clr_tag};
        end
        // Allocation wins over a clear at the same index.
        if (wr_en) begin
            mem_d[wr_idx] = {^{1'b1, wr_tag}, 1'b1, wr_tag};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_tag = mem_q[rd_idx][TAG_W-1:0];
    assign rd_vld = mem_q[rd_idx][TAG_W];
    assign rd_par = mem_q[rd_idx][TAG_W+1];
endmodule

// File: rtl/snoop_match.sv
module snoop_match #(
    parameter int unsigned TAG_W = 9
) (
    input  logic [TAG_W-1:0] ent_tag,
    input  logic             ent_vld,
    input  logic             ent_par,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             hit
);
    logic par_bad;
    logic tag_eq;

    always_comb begin
        par_bad = ^{ent_par, ent_vld, ent_tag};
        tag_eq  = (ent_tag == snp_tag);
        // A corrupted entry is reported as a hit: extra invalidate, never a lost one.
        hit     = (ent_vld && tag_eq) || par_bad;
    end
endmodule

// File: rtl/inv_queue.sv
module inv_queue #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } qctl_t;

    qctl_t      ctl_d, ctl_q;
    logic [W-1:0] slot_d [DEPTH];
    logic [W-1:0] slot_q [DEPTH];
    logic       do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ctl_d   = ctl_q;
        slot_d  = slot_q;
        do_push = push && (ctl_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (ctl_q.cnt != '0);
        if (do_push) begin
            slot_d[ctl_q.wr] = push_data;
            ctl_d.wr         = bump(ctl_q.wr);
        end
        if (do_pop) begin
            ctl_d.rd = bump(ctl_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        slot_q <= slot_d;
    end

    assign full      = (ctl_q.cnt == CNT_W'(DEPTH));
    assign out_valid = (ctl_q.cnt != '0);
    assign out_data  = slot_q[ctl_q.rd];
endmodule

// File: rtl/snoop_inv_unit.sv
module snoop_inv_unit
    import snoop_inv_pkg::*;
#(
    parameter int unsigned IDX_W  = SNP_IDX_W,
    parameter int unsigned TAG_W  = SNP_TAG_W,
    parameter int unsigned OFF_W  = SNP_OFF_W,
    parameter int unsigned QDEPTH = SNP_QDEPTH,
    localparam int unsigned ADDR_W = OFF_W + IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_ready,
    output logic              inv_valid,
    output logic [IDX_W-1:0]  inv_index,
    input  logic              inv_ready
);
    logic [IDX_W-1:0] a_idx, s_idx;
    logic [TAG_W-1:0] a_tag, s_tag;
    logic [TAG_W-1:0] ent_tag;
    logic             ent_vld, ent_par;
    logic             snp_hit, q_full, q_push, accept;
    logic             unused_offset_bits;

    assign a_idx = alloc_addr[OFF_W +: IDX_W];
    assign a_tag = alloc_addr[OFF_W + IDX_W +: TAG_W];
    assign s_idx = snoop_addr[OFF_W +: IDX_W];
    assign s_tag = snoop_addr[OFF_W + IDX_W +: TAG_W];
    assign unused_offset_bits = ^{alloc_addr[OFF_W-1:0], snoop_addr[OFF_W-1:0]};

    assign snoop_ready = !q_full;
    assign accept      = snoop_valid && snoop_ready;
    assign q_push      = accept && snp_hit;

    dtag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alloc_valid),
        .wr_idx  (a_idx),
        .wr_tag  (a_tag),
        .clr_en  (q_push),
        .clr_idx (s_idx),
        .rd_idx  (s_idx),
        .rd_tag  (ent_tag),
        .rd_vld  (ent_vld),
        .rd_par  (ent_par)
    );

    snoop_match #(.TAG_W(TAG_W)) u_match (
        .ent_tag (ent_tag),
        .ent_vld (ent_vld),
        .ent_par (ent_par),
        .snp_tag (s_tag),
        .hit     (snp_hit)
    );

    inv_queue #(.DEPTH(QDEPTH), .W(IDX_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (s_idx),
        .full      (q_full),
        .pop       (inv_ready),
        .out_valid (inv_valid),
        .out_data  (inv_index)
    );
endmodule

// File: rtl/snoop_inv_unit_chk.sv
module snoop_inv_unit_chk #(
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned TAG_W  = 9,
    parameter int unsigned OFF_W  = 5,
    parameter int unsigned QDEPTH = 4,
    localparam int unsigned ADDR_W = OFF_W + IDX_W + TAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic              snoop_valid,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              snoop_ready,
    input logic              inv_valid,
    input logic [IDX_W-1:0]  inv_index,
    input logic              inv_ready,
    input logic              push
);
    localparam int unsigned CNT_W = $clog2(QDEPTH + 1) + 1;

    logic [CNT_W-1:0] pend_q;
    logic             popped;

    assign popped = inv_valid && inv_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q + CNT_W'(push) - CNT_W'(popped);
        end
    end

    AST_READY_TRACKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_ready == (pend_q < CNT_W'(QDEPTH))); // R6

    AST_PUSH_ONLY_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (snoop_valid && snoop_ready)); // R6

    AST_REQ_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid == (pend_q != '0)); // R9

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_index))); // R5

    AST_ONE_INV_PER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !alloc_valid) |=>
            !(push && (snoop_addr[ADDR_W-1:OFF_W] == $past(snoop_addr[ADDR_W-1:OFF_W])))); // R4
endmodule

bind snoop_inv_unit snoop_inv_unit_chk #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .QDEPTH(QDEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .snoop_ready (snoop_ready),
    .inv_valid   (inv_valid),
    .inv_index   (inv_index),
    .inv_ready   (inv_ready),
    .push        (q_push)
);

// File: tb/snoop_inv_unit_test.sv
`timescale 1ns/1ps
module snoop_inv_unit_test;
    localparam int IDX_W  = 4;
    localparam int TAG_W  = 9;
    localparam int OFF_W  = 5;
    localparam int ADDR_W = OFF_W + IDX_W + TAG_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [ADDR_W-1:0] alloc_addr = '0;
    logic              snoop_valid = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic              snoop_ready;
    logic              inv_valid;
    logic [IDX_W-1:0]  inv_index;
    logic              inv_ready = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    snoop_inv_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .QDEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_ready(snoop_ready),
        .inv_valid(inv_valid), .inv_index(inv_index), .inv_ready(inv_ready)
    );

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
        return {TAG_W'(tag), IDX_W'(idx), OFF_W'(off)};
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic do_alloc(input int tag, input int idx);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_addr = mk(tag, idx, 0);
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic do_snoop(input int tag, input int idx, input int off);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = mk(tag, idx, off);
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic expect_pop(input string req, input int idx);
        check(req, "inv_valid", int'(inv_valid), 1);
        check(req, "inv_index", int'(inv_index), idx);
        inv_ready = 1'b1;
        @(negedge clk);
        inv_ready = 1'b0;
    endtask

    task automatic expect_none(input string req);
        check(req, "inv_valid (none expected)", int'(inv_valid), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "inv_valid after reset", int'(inv_valid), 0);
        check("R1", "snoop_ready after reset", int'(snoop_ready), 1);
        do_snoop(0, 0, 0);
        expect_none("R1");
        do_snoop(5, 9, 3);
        expect_none("R1");
    endtask

    task automatic t_basic_hit;
        do_alloc(9'h0A5, 3);
        do_snoop(9'h0A5, 3, 17);          // offset differs: still the same block (R3)
        expect_pop("R9", 3);              // visible one edge after acceptance
        expect_none("R2");
    endtask

    task automatic t_misses;
        do_alloc(5, 6);
        do_snoop(6, 6, 0);
        expect_none("R3");
        do_snoop(5, 7, 0);
        expect_none("R3");
        do_snoop(5, 6, 31);
        expect_pop("R2", 6);
    endtask

    task automatic t_clear_on_hit;
        do_alloc(1, 2);
        do_snoop(1, 2, 0);
        do_snoop(1, 2, 8);
        expect_pop("R4", 2);
        expect_none("R4");
    endtask

    task automatic t_full_queue;
        logic [IDX_W-1:0] held;
        for (int i = 0; i < 5; i++) do_alloc(9'h040 + i, i);
        for (int i = 0; i < 4; i++) do_snoop(9'h040 + i, i, 0);
        check("R6", "snoop_ready with four pending", int'(snoop_ready), 0);
        do_snoop(9'h044, 4, 0);           // presented while not ready: ignored
        check("R6", "snoop_ready still low", int'(snoop_ready), 0);
        held = inv_index;
        @(negedge clk);
        check("R5", "inv_valid held while stalled", int'(inv_valid), 1);
        check("R5", "inv_index held while stalled", int'(inv_index), int'(held));
        for (int i = 0; i < 4; i++) expect_pop("R5", i);
        expect_none("R6");
        check("R6", "snoop_ready after drain", int'(snoop_ready), 1);
        do_snoop(9'h044, 4, 0);           // entry untouched by the ignored write
        expect_pop("R6", 4);
    endtask

    task automatic t_same_cycle;
        do_alloc(7, 9);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_addr = mk(8, 9, 0);
        snoop_valid = 1'b1; snoop_addr = mk(7, 9, 0);
        @(negedge clk);
        alloc_valid = 1'b0; snoop_valid = 1'b0;
        expect_pop("R7", 9);              // compared with old tag 7
        do_snoop(8, 9, 0);                // new entry must still be valid
        expect_pop("R7", 9);
    endtask

    task automatic t_replace;
        do_alloc(2, 11);
        do_alloc(3, 11);
        do_snoop(2, 11, 0);
        expect_none("R8");
        do_snoop(3, 11, 0);
        expect_pop("R8", 11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic_hit();
        t_misses();
        t_clear_on_hit();
        t_full_queue();
        t_same_cycle();
        t_replace();
        repeat (2) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule